// File: doc/BRIEF.md
# PS/2 keyboard scan-code receiver

This block takes the clock and data lines of a PS/2 keyboard. It resynchronises them into the system clock domain and filters out short glitches. It then deserialises each frame into one scan-code byte. The newest valid byte is held on an output together with a ready flag. A rising edge on the read input drops that flag, so the flag and the read input form a simple handshake with the consumer.

On top of byte capture, the block follows the two prefix bytes a keyboard sends across frames:

- 0xF0 marks a key release.
- 0xE0 marks an extended key.

When a byte that is not a prefix arrives, the block pulses a one-cycle key-event strobe. Two flags come with the strobe: one says the key was released, the other says it is an extended key. A key that is held down produces a fresh press event for every typematic repeat. The block does not send commands to the keyboard and does not convert codes to characters.

Top module: `ps2_key_rx`

## Requirements
- R1: Synchronous active-high reset. After reset, `code_o` is 0x00 and `ready_o`, `evt_o`, `evt_break_o` and `evt_ext_o` are 0. Any prefix seen before reset is forgotten, so the first event after reset carries no release or extended flag from it.
- R2: The block samples a frame on falling edges of the filtered device clock. The frame is:
  - a start bit of 0;
  - eight data bits, least significant first;
  - a parity bit that makes the nine data and parity bits hold an odd number of ones;
  - a stop bit of 1.
  
  A valid frame loads its data byte into `code_o` and sets `ready_o`.
- R3: A frame with wrong parity or a stop bit of 0 is dropped. `code_o` and `ready_o` stay as they were.
- R4: A rising edge on `rd_i` clears `ready_o`. Holding `rd_i` high does not clear a byte that arrives afterwards.
- R5: If a read rising edge and a byte capture fall on the same clock edge, the capture wins and `ready_o` stays 1.
- R6: A captured byte other than 0xF0 or 0xE0 pulses `evt_o` high for exactly one cycle. With no prefix before it, `evt_break_o` and `evt_ext_o` are 0. Every repeat of the same code gives its own pulse.
- R7: 0xF0 followed by a code gives an event with `evt_break_o` = 1. The 0xF0 byte still appears on `code_o` with `ready_o`, but it raises no event.
- R8: 0xE0 before a code gives an event with `evt_ext_o` = 1. The sequence 0xE0 0xF0 code gives an event with both flags set.
- R9: The two flags keep their values until the next event. That next event shows only the prefixes received since the previous event.
- R10: If a frame has started and no falling device-clock edge arrives for TIMEOUT_CYC cycles, the receiver drops the partial frame. The next start bit then begins a fresh frame.
- R11: A low pulse on the device clock shorter than FILT_LEN system cycles is ignored.
- R12: A captured byte shows on `code_o`/`ready_o` at the (FILT_LEN+4)-th rising clock edge after the device clock's final falling edge is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Device clock line, asynchronous |
| ps2_dat_i | input | 1 | Device data line, asynchronous |
| rd_i | input | 1 | Read handshake; its rising edge clears `ready_o` |
| code_o | output | 8 | Most recent valid scan-code byte |
| ready_o | output | 1 | High while an unread byte is held |
| evt_o | output | 1 | One-cycle strobe when a key event completes |
| evt_break_o | output | 1 | Latest event was a release |
| evt_ext_o | output | 1 | Latest event was an extended key |

## Verification
Byte capture and the read-clear edge can land on the same clock edge. The bench provokes this by holding one byte unread and then sending a second frame. It raises `rd_i` at a swept offset of 2 to 12 cycles after driving the final device-clock fall.

The expected result comes from the fixed latency in R12:

- If the read edge lands at or before the capture edge, `ready_o` ends high. When both fall on the same edge, the capture takes priority.
- If the read edge lands later, `ready_o` ends low.

At every offset, `code_o` must hold the second byte.

// File: rtl/ps2_key_rx.sv
module ps2_key_rx #(
  parameter int FILT_LEN    = 4,
  parameter int TIMEOUT_CYC = 12500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       rd_i,
  output logic [7:0] code_o,
  output logic       ready_o,
  output logic       evt_o,
  output logic       evt_break_o,
  output logic       evt_ext_o
);

  localparam int         TW  = $clog2(TIMEOUT_CYC + 1);
  localparam logic [7:0] BRK = 8'hF0;
  localparam logic [7:0] EXT = 8'hE0;

  logic [1:0]          ck_s, dt_s;
  logic [FILT_LEN-1:0] ck_h, dt_h;
  logic                ck_f, dt_f, ck_fq;
  logic [3:0]          nbit;
  logic [8:0]          sh;
  logic [TW-1:0]       idle_cnt;
  logic                rd_q, brk_pend, ext_pend;
  logic                fall, cap, rd_rise, expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_s  <= 2'b11;
      dt_s  <= 2'b11;
      ck_h  <= '1;
      dt_h  <= '1;
      ck_f  <= 1'b1;
      dt_f  <= 1'b1;
      ck_fq <= 1'b1;
    end else begin
      ck_s  <= {ck_s[0], ps2_clk_i};
      dt_s  <= {dt_s[0], ps2_dat_i};
      ck_h  <= {ck_h[FILT_LEN-2:0], ck_s[1]};
      dt_h  <= {dt_h[FILT_LEN-2:0], dt_s[1]};
      if (&ck_h) ck_f <= 1'b1;
      else if (~|ck_h) ck_f <= 1'b0;
      if (&dt_h) dt_f <= 1'b1;
      else if (~|dt_h) dt_f <= 1'b0;
      ck_fq <= ck_f;
    end
  end

  assign fall    = ck_fq & ~ck_f;
  assign cap     = fall && (nbit == 4'd10) && dt_f && (^sh);
  assign rd_rise = rd_i & ~rd_q;
  assign expired = (nbit != 4'd0) && (idle_cnt == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      nbit     <= '0;
      sh       <= '0;
      idle_cnt <= '0;
    end else begin
      if (fall || nbit == 4'd0) idle_cnt <= '0;
      else idle_cnt <= idle_cnt + 1'b1;
      if (fall) begin
        if (nbit == 4'd0) nbit <= dt_f ? 4'd0 : 4'd1;
        else if (nbit == 4'd10) nbit <= 4'd0;
        else begin
          nbit <= nbit + 4'd1;
          sh   <= {dt_f, sh[8:1]};
        end
      end else if (expired) begin
        nbit <= 4'd0;
      end
    end
  end

  p_bitcount_r2: assert property (@(posedge clk) disable iff (rst) nbit <= 4'd10);
  p_timeout_r10: assert property (@(posedge clk) disable iff (rst)
    (nbit != 4'd0 && !fall && idle_cnt == TW'(TIMEOUT_CYC - 1)) |=> nbit == 4'd0);
  p_discard_r3: assert property (@(posedge clk) disable iff (rst)
    (fall && nbit == 4'd10 && !cap) |=> $stable(code_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q        <= 1'b0;
      code_o      <= '0;
      ready_o     <= 1'b0;
      evt_o       <= 1'b0;
      evt_break_o <= 1'b0;
      evt_ext_o   <= 1'b0;
      brk_pend    <= 1'b0;
      ext_pend    <= 1'b0;
    end else begin
      rd_q  <= rd_i;
      evt_o <= 1'b0;
      if (cap) ready_o <= 1'b1;
      else if (rd_rise) ready_o <= 1'b0;
      if (cap) begin
        code_o <= sh[7:0];
        if (sh[7:0] == BRK) brk_pend <= 1'b1;
        else if (sh[7:0] == EXT) ext_pend <= 1'b1;
        else begin
          evt_o       <= 1'b1;
          evt_break_o <= brk_pend;
          evt_ext_o   <= ext_pend;
          brk_pend    <= 1'b0;
          ext_pend    <= 1'b0;
        end
      end
    end
  end

  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_rise && !cap) |=> !ready_o);
  p_cap_wins_r5: assert property (@(posedge clk) disable iff (rst) cap |=> ready_o);
  p_evt_single_r6: assert property (@(posedge clk) disable iff (rst) evt_o |=> !evt_o);
  p_evt_code_r6: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> (ready_o && code_o != BRK && code_o != EXT));
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !evt_o |-> ($stable(evt_break_o) && $stable(evt_ext_o)));

endmodule

// File: tb/ps2_key_rx_bench.sv
module ps2_key_rx_bench;
  localparam int FILT = 4;
  localparam int TO   = 300;
  localparam int HALF = 20;
  localparam int LAT  = FILT + 4;

  logic clk = 1'b0, rst = 1'b1, pclk = 1'b1, pdat = 1'b1, rd = 1'b0;
  logic [7:0] code;
  logic ready, evt, ebrk, eext;

  int checks = 0, errors = 0, evt_cnt = 0, pulse_err = 0;
  logic ev_brk = 1'b0, ev_ext = 1'b0, prev_evt = 1'b0;
  logic [7:0] ev_code = 8'h00;
  bit done = 0;

  always #4 clk = ~clk;

  ps2_key_rx #(.FILT_LEN(FILT), .TIMEOUT_CYC(TO)) u_ps2_key_rx (
    .clk(clk), .rst(rst), .ps2_clk_i(pclk), .ps2_dat_i(pdat), .rd_i(rd),
    .code_o(code), .ready_o(ready), .evt_o(evt), .evt_break_o(ebrk), .evt_ext_o(eext));

  always @(negedge clk) begin
    if (evt) begin
      evt_cnt++;
      ev_brk  = ebrk;
      ev_ext  = eext;
      ev_code = code;
      if (prev_evt) pulse_err++;
    end
    prev_evt = evt;
  end

  function automatic logic [10:0] frame_bits(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    return {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
  endfunction

  function automatic logic [7:0] rand_code();
    logic [7:0] c = 8'($urandom);
    if (c == 8'hF0 || c == 8'hE0) c = c ^ 8'h01;
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clk_bit(input logic v, input bit glitch);
    pdat = v;
    repeat (HALF / 2) @(negedge clk);
    if (glitch) begin
      pclk = 1'b0;
      repeat (2) @(negedge clk);
      pclk = 1'b1;
    end
    repeat (HALF - HALF / 2) @(negedge clk);
    pclk = 1'b0;
    repeat (HALF) @(negedge clk);
    pclk = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par = 0, input bit bad_stop = 0,
                            input bit glitch = 0);
    logic [10:0] f = frame_bits(b, bad_par, bad_stop);
    for (int i = 0; i < 11; i++) clk_bit(f[i], glitch && i == 4);
    repeat (HALF) @(negedge clk);
  endtask

  task automatic read_pulse();
    rd = 1'b1;
    repeat (2) @(negedge clk);
    rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_event(input logic [7:0] c, input bit brk, input bit ext, input string req);
    int n = evt_cnt;
    if (ext) send_frame(8'hE0);
    if (brk) send_frame(8'hF0);
    send_frame(c);
    chk(evt_cnt == n + 1, req, "event count", evt_cnt, n + 1);
    chk(ev_brk == brk, req, "break flag", ev_brk, brk);
    chk(ev_ext == ext, req, "extended flag", ev_ext, ext);
    chk(ev_code == c && code == c, req, "event code", code, c);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    int n;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(code == 8'h00 && !ready && !evt && !ebrk && !eext, "R1", "reset outputs",
        {code, ready, evt, ebrk, eext}, 0);

    // R2 capture, R6 plain press
    send_frame(8'h1C);
    chk(code == 8'h1C && ready, "R2", "captured byte", {ready, code}, 9'h11C);
    chk(evt_cnt == 1 && !ev_brk && !ev_ext, "R6", "plain press event", evt_cnt, 1);

    // R4 read clears
    read_pulse();
    chk(!ready, "R4", "ready after read edge", ready, 0);

    // R3 bad parity, bad stop
    n = evt_cnt;
    send_frame(8'h55, 1, 0);
    chk(!ready && code == 8'h1C, "R3", "bad parity dropped", {ready, code}, 9'h01C);
    send_frame(8'h55, 0, 1);
    chk(!ready && code == 8'h1C && evt_cnt == n, "R3", "bad stop dropped", {ready, code}, 9'h01C);

    // R4 hold read high, later byte stays ready
    rd = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(8'h2B);
    chk(ready && code == 8'h2B, "R4", "byte after held read", {ready, code}, 9'h12B);
    rd = 1'b0;
    repeat (2) @(negedge clk);

    // R7 break prefix visible but no event
    n = evt_cnt;
    send_frame(8'hF0);
    chk(ready && code == 8'hF0 && evt_cnt == n, "R7", "prefix byte no event", evt_cnt, n);
    send_frame(8'h2B);
    chk(evt_cnt == n + 1 && ev_brk && !ev_ext, "R7", "release event", {ev_brk, ev_ext}, 2'b10);

    // R9 flags replaced by next event
    send_event(8'h2B, 0, 0, "R9");
    // R8 extended and extended release
    send_event(8'h74, 0, 1, "R8");
    send_event(8'h74, 1, 1, "R8");
    send_event(8'h15, 0, 0, "R9");

    // R6 typematic repeats
    n = evt_cnt;
    for (int i = 0; i < 3; i++) send_frame(8'h23);
    chk(evt_cnt == n + 3, "R6", "typematic repeats", evt_cnt, n + 3);
    chk(pulse_err == 0, "R6", "strobe width", pulse_err, 0);

    // R11 glitch on device clock
    send_frame(8'h6B, 0, 0, 1);
    chk(code == 8'h6B && ready, "R11", "glitch ignored", code, 8'h6B);

    // R10 timeout of partial frame
    begin
      logic [10:0] f = frame_bits(8'h3C, 0, 0);
      for (int i = 0; i < 4; i++) clk_bit(f[i], 0);
    end
    repeat (TO + 100) @(negedge clk);
    send_frame(8'hA5);
    chk(code == 8'hA5 && ready, "R10", "frame after timeout", code, 8'hA5);

    // R1 reset forgets pending prefix
    send_frame(8'hF0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!ready && code == 8'h00 && !ebrk && !eext, "R1", "mid-sequence reset", {ready, code}, 0);
    rst = 1'b0;
    @(negedge clk);
    send_event(8'h1C, 0, 0, "R1");

    // R5 / R12 read edge vs capture edge sweep
    for (int d = 2; d <= 12; d++) begin
      logic [10:0] f;
      c = rand_code();
      send_frame(8'h11);
      f = frame_bits(c, 0, 0);
      for (int i = 0; i < 10; i++) clk_bit(f[i], 0);
      pdat = 1'b1;
      repeat (HALF) @(negedge clk);
      pclk = 1'b0;
      repeat (d - 1) @(negedge clk);
      rd = 1'b1;
      repeat (HALF - (d - 1)) @(negedge clk);
      pclk = 1'b1;
      repeat (HALF) @(negedge clk);
      chk(ready == (d <= LAT), d == LAT ? "R5" : "R12", "ready after offset read", ready, d <= LAT);
      chk(code == c, "R12", "code after offset read", code, c);
      rd = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R6 R7 R8 random event mix
    for (int i = 0; i < 25; i++) begin
      int t = $urandom_range(0, 3);
      c = rand_code();
      send_event(c, t[0], t[1], "R8");
      if ($urandom_range(0, 1) == 1) begin
        read_pulse();
        chk(!ready, "R4", "random read", ready, 0);
      end
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule